// File: doc/BRIEF.md
# SAT Solver Decision Sequencer

This block is the control state machine of a hardware Boolean satisfiability solver. It decides variables one at a time in a fixed order. Decision level k always decides the variable whose tag is k, so the most frequently used variables, which carry the lowest tags, are decided first. After each decision it waits until the clause banks stop reporting fresh implications. When a conflict is reported, it starts conflict-clause recording, then backtracks non-chronologically to a level supplied from outside. It clears the base cells above that level, precharges the banks and re-applies the inverted decision at the target level.

The clause banks, the backtrack-level computation and the clause storage are outside this block; it only sequences them. Each level keeps a bit that records whether its decision has already been inverted. A level that has already been inverted is skipped when choosing where to backtrack. When no level at or below the requested one remains un-inverted, the instance is unsatisfiable. When the decision at the last level settles with no conflict, the instance is satisfiable. Each result flag stays high until the next start strobe.

Top module: `sat_seq`

## Requirements
- R1: While reset is held and directly after it, the block is idle and every output is low.
- R2: A start strobe while idle, satisfied or unsatisfiable gives one refresh cycle with both `refresh_o` and `clr_all_o` high. The next cycle is a decision with `dec_vld_o` high, tag 0, level 0 and value 0. Every earlier inverted flag is forgotten and any result flag drops.
- R3: A start strobe in any other state has no effect on the sequence.
- R4: After a decision, while `impl_i` is high and `conflict_i` is low, no further decision is issued and the block keeps waiting.
- R5: When the wait sees neither an implication nor a conflict and the level is not the last, the next cycle decides tag and level one higher. The value is 0 when that level has not been inverted (value 1 marks an inverted decision).
- R6: When the wait at level NUM_VARS-1 sees neither an implication nor a conflict, `sat_o` rises in the next cycle and holds until a start strobe.
- R7: A conflict seen during the wait takes priority over an implication. It gives exactly one cycle of `id_cclause_o`, followed by the backtrack cycle.
- R8: In the backtrack cycle the target is the highest level that is not yet inverted and not above the smaller of `bck_lvl_i` and the current level. If such a level exists, `bt_clr_o` is high for that cycle, with the target on `bt_lvl_o`.
- R9: After a backtrack, one precharge cycle follows, with `refresh_o` high and `clr_all_o` low. It is followed by a decision at the target level with value 1. The inverted flags of all levels above the target are forgotten.
- R10: If no eligible target exists in the backtrack cycle, `unsat_o` rises in the next cycle with no `bt_clr_o`. It holds until a start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a new solve |
| impl_i | input | 1 | OR of the per-variable new-implication pulses |
| conflict_i | input | 1 | Conflict reported by the clause banks |
| bck_lvl_i | input | LVL_W | Backtrack level from the level-compare network |
| refresh_o | output | 1 | Precharge strobe to the banks |
| clr_all_o | output | 1 | Clear strobe to all base cells |
| dec_vld_o | output | 1 | Decision strobe |
| dec_tag_o | output | LVL_W | Tag of the decided variable |
| dec_lvl_o | output | LVL_W | Decision level of the decision |
| dec_val_o | output | 1 | Decided value |
| id_cclause_o | output | 1 | Record conflict-clause literals |
| bt_clr_o | output | 1 | Clear base cells above `bt_lvl_o` |
| bt_lvl_o | output | LVL_W | Backtrack target level |
| sat_o | output | 1 | Instance satisfiable |
| unsat_o | output | 1 | Instance unsatisfiable |

## Verification
Two events can fall in the same cycle: a conflict and an implication can both be reported in one wait cycle, and a start strobe can arrive together with either of them. The random phase raises the three inputs independently, so all of these mixes occur. A bench model then judges them by checking that the conflict wins: the next cycle must be the conflict-clause cycle, not another wait, and the start strobe must leave no refresh. A second overlap is a backtrack request whose level is already inverted, or lies above the current level. Random `bck_lvl_i` values combined with a phase that forces conflicts in every wait cover this case, and the model checks each chosen `bt_lvl_o` and the final `unsat_o`.

// File: rtl/sat_seq_pkg.sv
package sat_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_REFRESH,
    ST_ASSIGN,
    ST_WAIT,
    ST_ANALYZE,
    ST_EXECUTE,
    ST_PRECHARGE,
    ST_SAT,
    ST_UNSAT
  } seq_state_e;
endpackage

// File: rtl/sat_seq_pick.sv
module sat_seq_pick #(
  parameter int NUM_LVL = 8,
  parameter int LVL_W   = 3
) (
  input  logic [NUM_LVL-1:0] flipped_i,
  input  logic [LVL_W-1:0]   lim_i,
  output logic               found_o,
  output logic [LVL_W-1:0]   tgt_o
);
  // highest non-inverted level not above the limit; later iterations win
  always_comb begin
    found_o = 1'b0;
    tgt_o   = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (LVL_W'(l) <= lim_i && !flipped_i[l]) begin
        found_o = 1'b1;
        tgt_o   = LVL_W'(l);
      end
    end
  end
endmodule

// File: rtl/sat_seq_lvl.sv
module sat_seq_lvl #(
  parameter int NUM_LVL = 8,
  parameter int LVL_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               init_i,
  input  logic               adv_i,
  input  logic               bt_go_i,
  input  logic [LVL_W-1:0]   tgt_i,
  output logic [LVL_W-1:0]   cur_lvl_o,
  output logic [NUM_LVL-1:0] flipped_o,
  output logic               last_o
);
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(NUM_LVL - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cur_lvl_o <= '0;
    else if (init_i)  cur_lvl_o <= '0;
    else if (bt_go_i) cur_lvl_o <= tgt_i;
    else if (adv_i)   cur_lvl_o <= cur_lvl_o + 1'b1;
  end

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_flip
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      flipped_o[g] <= 1'b0;
      else if (init_i)  flipped_o[g] <= 1'b0;
      else if (bt_go_i) begin
        if (LVL_W'(g) == tgt_i)     flipped_o[g] <= 1'b1;
        else if (LVL_W'(g) > tgt_i) flipped_o[g] <= 1'b0;
      end
    end
  end

  assign last_o = (cur_lvl_o == LAST_LVL);

  a_r5_step_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> cur_lvl_o == $past(cur_lvl_o) + 1'b1);
  a_r9_flip_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bt_go_i |=> (cur_lvl_o == $past(tgt_i)) && flipped_o[cur_lvl_o]);
  a_r2_init_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (cur_lvl_o == '0) && (flipped_o == '0));
endmodule

// File: rtl/sat_seq_fsm.sv
module sat_seq_fsm
  import sat_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       impl_i,
  input  logic       conflict_i,
  input  logic       last_i,
  input  logic       found_i,
  output seq_state_e state_o,
  output logic       init_o,
  output logic       adv_o,
  output logic       bt_go_o
);
  seq_state_e state_q, state_d;
  logic       ready;

  assign ready   = (state_q == ST_IDLE) || (state_q == ST_SAT) || (state_q == ST_UNSAT);
  assign init_o  = ready && start_i;
  assign adv_o   = (state_q == ST_WAIT) && !conflict_i && !impl_i && !last_i;
  assign bt_go_o = (state_q == ST_EXECUTE) && found_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_SAT, ST_UNSAT: if (start_i) state_d = ST_REFRESH;
      ST_REFRESH, ST_PRECHARGE:  state_d = ST_ASSIGN;
      ST_ASSIGN:                 state_d = ST_WAIT;
      ST_WAIT: begin
        if (conflict_i)  state_d = ST_ANALYZE;
        else if (impl_i) state_d = ST_WAIT;
        else if (last_i) state_d = ST_SAT;
        else             state_d = ST_ASSIGN;
      end
      ST_ANALYZE:                state_d = ST_EXECUTE;
      ST_EXECUTE:                state_d = found_i ? ST_PRECHARGE : ST_UNSAT;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  a_r3_busy_no_refresh: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready |=> state_q != ST_REFRESH);
  a_r4_hold_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && impl_i && !conflict_i) |=> state_q == ST_WAIT);
  a_r7_conflict_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && conflict_i) |=> state_q == ST_ANALYZE);
  a_r7_one_analyze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_ANALYZE |=> state_q == ST_EXECUTE);
  a_r6_sat_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SAT && !start_i) |=> state_q == ST_SAT);
  a_r10_unsat_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_UNSAT && !start_i) |=> state_q == ST_UNSAT);
endmodule

// File: rtl/sat_seq.sv
module sat_seq
  import sat_seq_pkg::*;
#(
  parameter int NUM_VARS = 8,
  localparam int LVL_W   = (NUM_VARS > 1) ? $clog2(NUM_VARS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             impl_i,
  input  logic             conflict_i,
  input  logic [LVL_W-1:0] bck_lvl_i,
  output logic             refresh_o,
  output logic             clr_all_o,
  output logic             dec_vld_o,
  output logic [LVL_W-1:0] dec_tag_o,
  output logic [LVL_W-1:0] dec_lvl_o,
  output logic             dec_val_o,
  output logic             id_cclause_o,
  output logic             bt_clr_o,
  output logic [LVL_W-1:0] bt_lvl_o,
  output logic             sat_o,
  output logic             unsat_o
);
  seq_state_e          state;
  logic                init, adv, bt_go, last, found;
  logic [LVL_W-1:0]    cur_lvl, lim, tgt;
  logic [NUM_VARS-1:0] flipped;

  sat_seq_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .impl_i     (impl_i),
    .conflict_i (conflict_i),
    .last_i     (last),
    .found_i    (found),
    .state_o    (state),
    .init_o     (init),
    .adv_o      (adv),
    .bt_go_o    (bt_go)
  );

  sat_seq_lvl #(.NUM_LVL(NUM_VARS), .LVL_W(LVL_W)) u_lvl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .init_i    (init),
    .adv_i     (adv),
    .bt_go_i   (bt_go),
    .tgt_i     (tgt),
    .cur_lvl_o (cur_lvl),
    .flipped_o (flipped),
    .last_o    (last)
  );

  // never backtrack above the level currently being decided
  assign lim = (bck_lvl_i < cur_lvl) ? bck_lvl_i : cur_lvl;

  sat_seq_pick #(.NUM_LVL(NUM_VARS), .LVL_W(LVL_W)) u_pick (
    .flipped_i (flipped),
    .lim_i     (lim),
    .found_o   (found),
    .tgt_o     (tgt)
  );

  assign refresh_o    = (state == ST_REFRESH) || (state == ST_PRECHARGE);
  assign clr_all_o    = (state == ST_REFRESH);
  assign dec_vld_o    = (state == ST_ASSIGN);
  assign dec_tag_o    = dec_vld_o ? cur_lvl : '0;
  assign dec_lvl_o    = dec_vld_o ? cur_lvl : '0;
  assign dec_val_o    = dec_vld_o && flipped[cur_lvl];
  assign id_cclause_o = (state == ST_ANALYZE);
  assign bt_clr_o     = bt_go;
  assign bt_lvl_o     = bt_go ? tgt : '0;
  assign sat_o        = (state == ST_SAT);
  assign unsat_o      = (state == ST_UNSAT);

  a_r8_target_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bt_clr_o |-> (bt_lvl_o <= bck_lvl_i) && (bt_lvl_o <= cur_lvl) && !flipped[bt_lvl_o]);
  a_r9_precharge_then_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bt_clr_o |=> refresh_o && !clr_all_o ##1 dec_vld_o && dec_val_o);
  a_r2_refresh_then_decide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_all_o |=> dec_vld_o && (dec_lvl_o == '0) && !dec_val_o);
  a_r10_unsat_no_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unsat_o) |-> !$past(bt_clr_o));
endmodule

// File: tb/sat_seq_bench.sv
module sat_seq_bench;
  localparam int N  = 8;
  localparam int LW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, impl = 1'b0, confl = 1'b0;
  logic [LW-1:0] bck = '0;
  logic          refresh, clr_all, dec_vld, dec_val, id_cc, bt_clr, sat, unsat;
  logic [LW-1:0] dec_tag, dec_lvl, bt_lvl;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  sat_seq #(.NUM_VARS(N)) u_sat_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .impl_i(impl),
    .conflict_i(confl), .bck_lvl_i(bck), .refresh_o(refresh),
    .clr_all_o(clr_all), .dec_vld_o(dec_vld), .dec_tag_o(dec_tag),
    .dec_lvl_o(dec_lvl), .dec_val_o(dec_val), .id_cclause_o(id_cc),
    .bt_clr_o(bt_clr), .bt_lvl_o(bt_lvl), .sat_o(sat), .unsat_o(unsat)
  );

  // model states: 0 idle 1 refresh 2 assign 3 wait 4 analyze 5 execute 6 precharge 7 sat 8 unsat
  int ms = 0;
  int mlvl = 0;
  bit mflip [N];
  int seen_sat = 0, seen_unsat = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int pick_tgt(input int bk, input int cur);
    int lim = (bk < cur) ? bk : cur;
    for (int l = lim; l >= 0; l--) if (!mflip[l]) return l;
    return -1;
  endfunction

  task automatic check_outputs();
    int t = (ms == 5) ? pick_tgt(int'(bck), mlvl) : -1;
    bit e_dec = (ms == 2);
    bit e_bt  = (t >= 0);
    chk(refresh == (ms == 1 || ms == 6), (ms == 6) ? "R9" : "R2", "refresh_o", int'(refresh), int'(ms == 1 || ms == 6));
    chk(clr_all == (ms == 1), "R2", "clr_all_o", int'(clr_all), int'(ms == 1));
    chk(dec_vld == e_dec, "R4", "dec_vld_o", int'(dec_vld), int'(e_dec));
    if (e_dec) begin
      chk(int'(dec_tag) == mlvl, "R5", "dec_tag_o", int'(dec_tag), mlvl);
      chk(int'(dec_lvl) == mlvl, "R5", "dec_lvl_o", int'(dec_lvl), mlvl);
      chk(dec_val == mflip[mlvl], "R9", "dec_val_o", int'(dec_val), int'(mflip[mlvl]));
    end
    chk(id_cc == (ms == 4), "R7", "id_cclause_o", int'(id_cc), int'(ms == 4));
    chk(bt_clr == e_bt, "R8", "bt_clr_o", int'(bt_clr), int'(e_bt));
    if (e_bt) chk(int'(bt_lvl) == t, "R8", "bt_lvl_o", int'(bt_lvl), t);
    chk(sat == (ms == 7), "R6", "sat_o", int'(sat), int'(ms == 7));
    chk(unsat == (ms == 8), "R10", "unsat_o", int'(unsat), int'(ms == 8));
    if (ms == 7) seen_sat++;
    if (ms == 8) seen_unsat++;
  endtask

  task automatic model_step();
    int t;
    case (ms)
      0, 7, 8: if (start) begin
        ms = 1; mlvl = 0;
        for (int l = 0; l < N; l++) mflip[l] = 1'b0;
      end
      1, 6: ms = 2;
      2: ms = 3;
      3: begin
        if (confl)             ms = 4;
        else if (impl)         ms = 3;
        else if (mlvl == N-1)  ms = 7;
        else begin mlvl++; ms = 2; end
      end
      4: ms = 5;
      5: begin
        t = pick_tgt(int'(bck), mlvl);
        if (t >= 0) begin
          mlvl = t; mflip[t] = 1'b1;
          for (int l = t + 1; l < N; l++) mflip[l] = 1'b0;
          ms = 6;
        end else ms = 8;
      end
      default: ms = 0;
    endcase
  endtask

  // mode 0: mixed random, 1: conflict in every wait, 2: never a conflict
  task automatic run(input int mode, input int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      check_outputs();
      start = ((ms == 0 || ms == 7 || ms == 8) ? ($urandom % 4 == 0) : ($urandom % 8 == 0));
      impl  = ($urandom % 5) < 2;
      confl = (mode == 1) ? 1'b1 : (mode == 2) ? 1'b0 : ($urandom % 9 == 0);
      bck   = LW'($urandom % N);
      model_step();
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int l = 0; l < N; l++) mflip[l] = 1'b0;
    @(negedge clk);
    chk(!(refresh | clr_all | dec_vld | id_cc | bt_clr | sat | unsat), "R1", "outputs in reset", 1, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!(refresh | clr_all | dec_vld | id_cc | bt_clr | sat | unsat), "R1", "outputs after reset", 1, 0);
    // directed: start, then hold an implication across several waits (R4, R3)
    start = 1'b1; model_step(); @(negedge clk); check_outputs();
    start = 1'b0; model_step(); @(negedge clk); check_outputs();
    model_step(); @(negedge clk); check_outputs();
    for (int k = 0; k < 4; k++) begin
      impl = 1'b1; start = 1'b1; model_step(); @(negedge clk); check_outputs();
    end
    impl = 1'b0; start = 1'b0; model_step();
    run(2, 300);
    run(1, 800);
    run(0, 20000);
    run(2, 400);
    run(1, 600);
    chk(seen_sat > 0, "R6", "satisfied reached", seen_sat, 1);
    chk(seen_unsat > 0, "R10", "unsatisfiable reached", seen_unsat, 1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule